// File: doc/BRIEF.md
# Multiplexed General-Purpose I/O Port

This block controls one bank of I/O pins (32 by default). For each pin it chooses who drives the pad. Either the port's own output value and output enable drive it, or one of eight peripheral functions does. The peripheral is picked by a 3-bit index held across three separate select registers.

The block also holds the pad controls: pull-up, pull-down, open-drain mode and two drive-strength bits. When a pin has both pulls enabled, it reports keeper mode instead. The level on each pin is sampled through a two-flop synchronizer and can be read back. This pin-level read is independent of the programmed output value.

Software reaches the port through a simple register bus. A write carries a register index and an operation code. The operation is a plain write, set-ones, clear-ones or toggle-ones. The output value and output enable registers accept all four operations. The other control registers ignore toggle. Open-drain style signalling works without the open-drain bit: hold the output value at 0 and toggle the output enable. The enable bit then stands for "pull low", and the line floats otherwise.

Top module: `pio_mux_port`

## Requirements
- R1: After reset every pin is GPIO-controlled (enable register all ones). Output enable, output value, pulls, open-drain, drive-strength and all three select registers are zero, so every pad is an undriven input.
- R2: A write uses `wr_addr = {index[3:0], op[1:0]}`. The op codes are 0 write, 1 set, 2 clear and 3 toggle. The register indices are: 0 select bit 0, 1 select bit 1, 2 select bit 2, 3 GPIO enable, 4 output enable, 5 output value, 6 pull-up, 7 pull-down, 8 open-drain, 9 drive bit 0, 10 drive bit 1. A set writes one to each bit given as one and leaves the others unchanged. Results read back at `rd_addr = index` from the cycle after the write edge.
- R3: A clear zeroes each bit given as one and leaves the others unchanged.
- R4: A toggle inverts each bit given as one in the output value and output enable registers. A toggle aimed at any other register has no effect.
- R5: Writes to index 11 (the read-only pin level) or to indices 12 to 15 change no register.
- R6: When a pin's GPIO enable bit is 0, the pin takes output and enable from peripheral function number {sel2, sel1, sel0}. Index 0 is the first function and index 7 is the last.
- R7: When a pin's GPIO enable bit is 1, its pad enable equals its output enable bit and peripheral signals are ignored.
- R8: `pad_out` of a pin is 0 whenever its `pad_oe` is 0.
- R9: With output value 0 under GPIO control, each toggle of the output enable bit flips `pad_oe` while `pad_out` stays 0.
- R10: Pull-up alone gives `pad_pull_up` and pull-down alone gives `pad_pull_dn`. Both together give only `pad_keeper`.
- R11: Index 11 reads the pin levels `pad_in` delayed by two clock edges.
- R12: A plain write replaces the whole register. The open-drain and drive bits appear on `pad_odm`, `pad_drv0` and `pad_drv1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Register index and operation code |
| wr_data | input | N | Write data / bit mask |
| rd_addr | input | 4 | Read register index |
| rd_data | output | N | Read data (combinational) |
| per_out | input | 8*N | Peripheral output levels, function f at bits f*N+pin |
| per_oe | input | 8*N | Peripheral output enables, same layout |
| pad_in | input | N | Pad input levels |
| pad_out | output | N | Pad output level |
| pad_oe | output | N | Pad output driver enable |
| pad_pull_up | output | N | Pull-up active |
| pad_pull_dn | output | N | Pull-down active |
| pad_keeper | output | N | Bus keeper active |
| pad_odm | output | N | Open-drain mode |
| pad_drv0 | output | N | Drive strength bit 0 |
| pad_drv1 | output | N | Drive strength bit 1 |

## Verification
The bench builds the port at its default width of 32 pins. At that width the top bit of every register and of the flattened peripheral vectors is exercised, including mask patterns that span both halves of the word. Each of the eight function slices is placed on a distinct bit range of `per_out`. Selecting indices 0, 4, 5 and 7 on one pin therefore proves that all three select registers steer the mux.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int NFUNC   = 8;
    localparam int FSEL_W  = 3;
    localparam int IDX_W   = 4;
    localparam int ADDR_W  = IDX_W + 2;

    localparam int REG_SEL0  = 0;
    localparam int REG_SEL1  = 1;
    localparam int REG_SEL2  = 2;
    localparam int REG_GPEN  = 3;
    localparam int REG_OEN   = 4;
    localparam int REG_OVAL  = 5;
    localparam int REG_PUP   = 6;
    localparam int REG_PDN   = 7;
    localparam int REG_ODM   = 8;
    localparam int REG_DRV0  = 9;
    localparam int REG_DRV1  = 10;
    localparam int NREG      = 11;
    localparam int REG_PINV  = 11;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TGL   = 2'd3
    } pio_op_e;
endpackage

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg #(
    parameter int N        = 32,
    parameter bit RST_ONES = 1'b0,
    parameter bit TGL_EN   = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit,
    input  pio_pkg::pio_op_e   op,
    input  logic [N-1:0]       data,
    output logic [N-1:0]       q
);
    import pio_pkg::*;

    localparam logic [N-1:0] RST_VAL = RST_ONES ? {N{1'b1}} : {N{1'b0}};

    logic [N-1:0] nxt;

    always_comb begin
        nxt = q;
        if (hit) begin
            unique case (op)
                OP_WRITE: nxt = data;
                OP_SET:   nxt = q | data;
                OP_CLR:   nxt = q & ~data;
                OP_TGL:   nxt = TGL_EN ? (q ^ data) : q;
                default:  nxt = q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= nxt;
    end
endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pio_pin_mux.sv
module pio_pin_mux #(
    parameter int NF = pio_pkg::NFUNC
) (
    input  logic                       gp_en,
    input  logic                       oval,
    input  logic                       oen,
    input  logic [pio_pkg::FSEL_W-1:0] fsel,
    input  logic [NF-1:0]              f_out,
    input  logic [NF-1:0]              f_oe,
    output logic                       pad_out,
    output logic                       pad_oe
);
    logic drv_val;
    logic drv_en;

    always_comb begin
        if (gp_en) begin
            drv_val = oval;
            drv_en  = oen;
        end else begin
            drv_val = f_out[fsel];
            drv_en  = f_oe[fsel];
        end
        pad_oe  = drv_en;
        pad_out = drv_val & drv_en;
    end
endmodule

// File: rtl/pio_mux_port.sv
module pio_mux_port #(
    parameter int N = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [pio_pkg::ADDR_W-1:0]         wr_addr,
    input  logic [N-1:0]                       wr_data,
    input  logic [pio_pkg::IDX_W-1:0]          rd_addr,
    output logic [N-1:0]                       rd_data,
    input  logic [pio_pkg::NFUNC*N-1:0]        per_out,
    input  logic [pio_pkg::NFUNC*N-1:0]        per_oe,
    input  logic [N-1:0]                       pad_in,
    output logic [N-1:0]                       pad_out,
    output logic [N-1:0]                       pad_oe,
    output logic [N-1:0]                       pad_pull_up,
    output logic [N-1:0]                       pad_pull_dn,
    output logic [N-1:0]                       pad_keeper,
    output logic [N-1:0]                       pad_odm,
    output logic [N-1:0]                       pad_drv0,
    output logic [N-1:0]                       pad_drv1
);
    import pio_pkg::*;

    logic [IDX_W-1:0]          wr_idx;
    pio_op_e                   wr_op;
    logic [NREG-1:0]           reg_hit;
    logic [NREG-1:0][N-1:0]    ctl_q;
    logic [N-1:0]              pinv_q;

    assign wr_idx = wr_addr[ADDR_W-1:2];
    assign wr_op  = pio_op_e'(wr_addr[1:0]);

    // Control registers; only output value and output enable honour toggle.
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam bit IS_ONES = (r == REG_GPEN);
        localparam bit CAN_TGL = (r == REG_OEN) || (r == REG_OVAL);
        assign reg_hit[r] = wr_en && (wr_idx == IDX_W'(r));
        pio_ctrl_reg #(.N(N), .RST_ONES(IS_ONES), .TGL_EN(CAN_TGL)) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .hit  (reg_hit[r]),
            .op   (wr_op),
            .data (wr_data),
            .q    (ctl_q[r])
        );
    end

    pio_sync #(.N(N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (pinv_q)
    );

    // Read-back mux.
    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NREG; r++) begin
            if (rd_addr == IDX_W'(r)) rd_data = ctl_q[r];
        end
        if (rd_addr == IDX_W'(REG_PINV)) rd_data = pinv_q;
    end

    // Per-pin ownership mux.
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic [NFUNC-1:0] f_out;
        logic [NFUNC-1:0] f_oe;
        for (genvar f = 0; f < NFUNC; f++) begin : g_fn
            assign f_out[f] = per_out[f*N + i];
            assign f_oe[f]  = per_oe[f*N + i];
        end
        pio_pin_mux #(.NF(NFUNC)) u_mux (
            .gp_en  (ctl_q[REG_GPEN][i]),
            .oval   (ctl_q[REG_OVAL][i]),
            .oen    (ctl_q[REG_OEN][i]),
            .fsel   ({ctl_q[REG_SEL2][i], ctl_q[REG_SEL1][i], ctl_q[REG_SEL0][i]}),
            .f_out  (f_out),
            .f_oe   (f_oe),
            .pad_out(pad_out[i]),
            .pad_oe (pad_oe[i])
        );
    end

    // Pad electrical controls.
    assign pad_keeper  = ctl_q[REG_PUP] & ctl_q[REG_PDN];
    assign pad_pull_up = ctl_q[REG_PUP] & ~ctl_q[REG_PDN];
    assign pad_pull_dn = ctl_q[REG_PDN] & ~ctl_q[REG_PUP];
    assign pad_odm     = ctl_q[REG_ODM];
    assign pad_drv0    = ctl_q[REG_DRV0];
    assign pad_drv1    = ctl_q[REG_DRV1];
endmodule

// File: rtl/pio_mux_port_chk.sv
module pio_mux_port_chk #(
    parameter int N = 32
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   wr_en,
    input logic [pio_pkg::ADDR_W-1:0]             wr_addr,
    input logic [N-1:0]                           wr_data,
    input logic [pio_pkg::NREG-1:0][N-1:0]        ctl_q,
    input logic [N-1:0]                           pinv_q,
    input logic [N-1:0]                           pad_in,
    input logic [N-1:0]                           pad_out,
    input logic [N-1:0]                           pad_oe,
    input logic [N-1:0]                           pad_pull_up,
    input logic [N-1:0]                           pad_pull_dn,
    input logic [N-1:0]                           pad_keeper
);
    import pio_pkg::*;

    logic [IDX_W-1:0] idx;
    logic [1:0]       op;
    logic [1:0]       up_cnt;

    assign idx = wr_addr[ADDR_W-1:2];
    assign op  = wr_addr[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              up_cnt <= '0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    AST_RESET_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0)); // R1

    AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_W'(REG_OVAL) && op == 2'd1)
        |=> ctl_q[REG_OVAL] == ($past(ctl_q[REG_OVAL]) | $past(wr_data))); // R2

    AST_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_W'(REG_OVAL) && op == 2'd2)
        |=> ctl_q[REG_OVAL] == ($past(ctl_q[REG_OVAL]) & ~$past(wr_data))); // R3

    AST_TGL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_W'(REG_OVAL) && op == 2'd3)
        |=> ctl_q[REG_OVAL] == ($past(ctl_q[REG_OVAL]) ^ $past(wr_data))); // R4

    AST_TGL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_W'(REG_PUP) && op == 2'd3)
        |=> $stable(ctl_q)); // R4

    AST_RO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx >= IDX_W'(REG_PINV)) |=> $stable(ctl_q)); // R5

    AST_OE_GATES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0); // R8

    AST_KEEPER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_keeper & (pad_pull_up | pad_pull_dn)) == '0); // R10

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2) |-> pinv_q == $past(pad_in, 2)); // R11
endmodule

bind pio_mux_port pio_mux_port_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ctl_q      (ctl_q),
    .pinv_q     (pinv_q),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pad_pull_up(pad_pull_up),
    .pad_pull_dn(pad_pull_dn),
    .pad_keeper (pad_keeper)
);

// File: tb/tb_pio_mux_port.sv
`timescale 1ns/100ps
module tb_pio_mux_port;
    localparam int N = 32;
    localparam int NF = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [5:0]      wr_addr = '0;
    logic [N-1:0]    wr_data = '0;
    logic [3:0]      rd_addr = '0;
    logic [N-1:0]    rd_data;
    logic [NF*N-1:0] per_out = '0;
    logic [NF*N-1:0] per_oe = '0;
    logic [N-1:0]    pad_in = '0;
    logic [N-1:0]    pad_out, pad_oe, pad_pull_up, pad_pull_dn, pad_keeper;
    logic [N-1:0]    pad_odm, pad_drv0, pad_drv1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pio_mux_port #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .per_out(per_out), .per_oe(per_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_up(pad_pull_up),
        .pad_pull_dn(pad_pull_dn), .pad_keeper(pad_keeper),
        .pad_odm(pad_odm), .pad_drv0(pad_drv0), .pad_drv1(pad_drv1)
    );

    typedef struct packed {
        logic [3:0]  idx;
        logic [1:0]  op;
        logic [31:0] data;
        logic [3:0]  ridx;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{4'd5,  2'd1, 32'h0000_00F0, 4'd5, 32'h0000_00F0}, // R2 set
        '{4'd5,  2'd1, 32'h0000_000F, 4'd5, 32'h0000_00FF}, // R2 set keeps others
        '{4'd5,  2'd2, 32'h0000_003C, 4'd5, 32'h0000_00C3}, // R3 clear
        '{4'd5,  2'd3, 32'hFF00_00FF, 4'd5, 32'hFF00_003C}, // R4 toggle value
        '{4'd4,  2'd0, 32'hAAAA_5555, 4'd4, 32'hAAAA_5555}, // R12 plain write
        '{4'd4,  2'd3, 32'hFFFF_FFFF, 4'd4, 32'h5555_AAAA}, // R4 toggle enable
        '{4'd6,  2'd3, 32'h0000_0001, 4'd6, 32'h0000_0000}, // R4 toggle ignored
        '{4'd6,  2'd1, 32'h0000_0003, 4'd6, 32'h0000_0003}, // R2 set pull-up
        '{4'd11, 2'd0, 32'hFFFF_FFFF, 4'd11, 32'h0000_0000}, // R5 pin level read-only
        '{4'd15, 2'd1, 32'hFFFF_FFFF, 4'd0, 32'h0000_0000}, // R5 unused index
        '{4'd3,  2'd2, 32'h8000_0001, 4'd3, 32'h7FFF_FFFE}, // R3 clear gpio enable
        '{4'd10, 2'd0, 32'h0000_0080, 4'd10, 32'h0000_0080}  // R12 drive bit 1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [1:0] op, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {idx, op}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] v);
        rd_addr = idx;
        #0.5;
        v = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        for (int r = 0; r < 11; r++) begin
            rd(4'(r), v);
            chk($sformatf("R1 reg%0d", r), v, (r == 3) ? 32'hFFFF_FFFF : 32'h0);
        end
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 pad_out", pad_out, 32'h0);
        chk("R1 pulls", pad_pull_up | pad_pull_dn | pad_keeper, 32'h0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            wr(VEC[k].idx, VEC[k].op, VEC[k].data);
            rd(VEC[k].ridx, v);
            chk($sformatf("vec%0d", k), v, VEC[k].exp);
        end
        rd(4'd5, v);
        chk("R5 value after ro writes", v, 32'hFF00_003C);
        rd(4'd3, v);
        chk("R5 enable after unused idx", v, 32'h7FFF_FFFE);
        chk("R12 pad_drv1", pad_drv1, 32'h0000_0080);

        // R6/R8 peripheral mux on pin 5
        do_reset();
        for (int f = 0; f < NF; f++) begin
            per_out[f*N +: N] = (f == 5 || f == 7) ? 32'hFFFF_FFFF : 32'h0;
            per_oe[f*N +: N]  = 32'hFFFF_FFFF;
        end
        wr(4'd3, 2'd2, 32'h0000_0020);
        chk("R6 idx0 out", 32'(pad_out[5]), 32'd0);
        chk("R6 idx0 oe", 32'(pad_oe[5]), 32'd1);
        wr(4'd0, 2'd1, 32'h0000_0020);
        wr(4'd2, 2'd1, 32'h0000_0020);
        chk("R6 idx5 out", 32'(pad_out[5]), 32'd1);
        wr(4'd1, 2'd1, 32'h0000_0020);
        chk("R6 idx7 out", 32'(pad_out[5]), 32'd1);
        wr(4'd0, 2'd2, 32'h0000_0020);
        wr(4'd1, 2'd2, 32'h0000_0020);
        chk("R6 idx4 out", 32'(pad_out[5]), 32'd0);
        wr(4'd0, 2'd1, 32'h0000_0020);
        per_oe[5*N +: N] = 32'h0;
        #0.5;
        chk("R8 masked out", 32'(pad_out[5]), 32'd0);
        chk("R8 masked oe", 32'(pad_oe[5]), 32'd0);

        // R7 GPIO ownership ignores peripherals on pin 9
        per_oe[0 +: N] = 32'h0;
        wr(4'd5, 2'd1, 32'h0000_0200);
        wr(4'd4, 2'd1, 32'h0000_0200);
        chk("R7 out", 32'(pad_out[9]), 32'd1);
        chk("R7 oe", 32'(pad_oe[9]), 32'd1);

        // R9 open-drain emulation on pin 3
        wr(4'd5, 2'd2, 32'h0000_0008);
        wr(4'd4, 2'd3, 32'h0000_0008);
        chk("R9 drive low oe", 32'(pad_oe[3]), 32'd1);
        chk("R9 drive low out", 32'(pad_out[3]), 32'd0);
        wr(4'd4, 2'd3, 32'h0000_0008);
        chk("R9 release oe", 32'(pad_oe[3]), 32'd0);

        // R10 pull combinations
        wr(4'd6, 2'd1, 32'h0000_0004);
        chk("R10 pull-up alone", pad_pull_up, 32'h0000_0004);
        wr(4'd7, 2'd1, 32'h0000_0014);
        chk("R10 keeper", pad_keeper, 32'h0000_0004);
        chk("R10 pull-up cleared", pad_pull_up, 32'h0);
        chk("R10 pull-down alone", pad_pull_dn, 32'h0000_0010);

        // R12 open-drain bit on pad
        wr(4'd8, 2'd0, 32'h8000_0001);
        chk("R12 pad_odm", pad_odm, 32'h8000_0001);

        // R11 two-edge synchronizer
        rd_addr = 4'd11;
        pad_in = 32'h1234_5678;
        @(negedge clk);
        chk("R11 after one edge", rd_data, 32'h0);
        @(negedge clk);
        chk("R11 after two edges", rd_data, 32'h1234_5678);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule